// File: doc/BRIEF.md
# Segmented LRU Replacement Controller

This block holds the replacement state of one fully associative set of `LINES` lines that are managed under a two-segment recency policy. Every valid line sits in either the probation segment or the protected segment, and each segment is kept in recency order. The protected segment holds at most `PROT_CAP` lines. The block does no tag matching and stores no data. In each cycle the surrounding cache reports at most one event, which is either a hit on a line index or the fill of a line index after a miss. From this state the block continuously reports which line should be evicted next.

A line that misses and is filled enters probation as its most recent member. A line that hits is moved to the most recent position of the protected segment. If that promotion overfills the protected segment, its oldest member is demoted to the most recent position of probation instead of being evicted, so the line gets a second chance. The eviction candidate is, in order of preference: the lowest-index invalid line, then the oldest probation line, and then, only when probation is empty, the oldest protected line.

Internally each line carries a valid bit, a segment bit and a rank within its segment, where rank 0 is the most recent. All ranks are recomputed in parallel for every event, so an update takes one clock. The per-cycle event is decoded into four named kinds. EV_IDLE: no event, so the state holds. EV_HIT: a hit on a valid line. EV_FILL: a fill with no hit in the same cycle. EV_DROP: a hit on an invalid line, so the state holds. The transitions a line can take are:
- PROB→PROT: a hit in probation, which is a promotion.
- PROT→PROT: a hit in the protected segment, which reorders it.
- PROT→PROB: a demotion on overflow.
- any→PROB: a fill, which inserts the line or reinserts it.

Top module: `slru_ctrl`

## Requirements
- R1: After reset every line is invalid, `victim_idx` is 0 and `victim_free` is 1.
- R2: A fill (`fill_en`=1, `hit_en`=0) makes the line valid and places it at the most recent end of the probation segment. All other probation lines age by one position.
- R3: A hit on a valid probation line removes it from probation and places it at the most recent end of the protected segment.
- R4: The protected segment never holds more than `PROT_CAP` lines. A promotion into a full protected segment moves the oldest protected line to the most recent end of probation.
- R5: A hit on a valid protected line moves it to the most recent end of the protected segment. If the line is already at that end, the state does not change.
- R6: While any line is invalid, `victim_idx` is the lowest invalid index and `victim_free` is 1.
- R7: When all lines are valid and probation is not empty, `victim_idx` is the oldest probation line and `victim_free` is 0.
- R8: When all lines are valid and probation is empty, `victim_idx` is the oldest protected line and `victim_free` is 0.
- R9: A hit on an invalid line changes nothing.
- R10: When `hit_en` and `fill_en` are both 1 in the same cycle, the hit is processed and the fill is ignored.
- R11: A fill of a line that is already valid first removes that line from its current segment position and then inserts it as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_en | input | 1 | A hit event occurs this cycle |
| hit_idx | input | $clog2(LINES) | Line index of the hit |
| fill_en | input | 1 | A fill event occurs this cycle |
| fill_idx | input | $clog2(LINES) | Line index being filled |
| victim_idx | output | $clog2(LINES) | Line to evict next |
| victim_free | output | 1 | The named victim is an invalid line |

## Verification
The assertions assume that every index input is below `LINES`. They also assume that the surrounding cache normally presents at most one event per cycle, although a simultaneous hit and fill is still checked against the priority rule. The random stimulus only draws indices in range. It fills either at the reported victim or at a random line, which covers refills of valid lines. It raises both strobes together only in one directed case. A second instance, whose protected capacity equals the line count, reaches the state in which probation is empty.

// File: rtl/slru_pkg.sv
package slru_pkg;

    // Segment a line belongs to
    typedef enum logic {
        SEG_PROB = 1'b0,
        SEG_PROT = 1'b1
    } seg_e;

    // Decoded per-cycle event
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_HIT  = 2'd1,
        EV_FILL = 2'd2,
        EV_DROP = 2'd3
    } ev_e;

endpackage

// File: rtl/slru_line_next.sv
module slru_line_next
    import slru_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int PROT_CAP = 3,
    localparam int RW      = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  ev_e           ev,
    input  logic          is_tgt,
    input  logic          cur_valid,
    input  logic          cur_seg,
    input  logic [RW-1:0] cur_rank,
    input  logic          tgt_valid,
    input  logic          tgt_seg,
    input  logic [RW-1:0] tgt_rank,
    input  logic          prot_full,
    output logic          nxt_valid,
    output logic          nxt_seg,
    output logic [RW-1:0] nxt_rank
);

    localparam logic [RW-1:0] PROT_LAST = RW'(PROT_CAP - 1);

    logic          same_seg_older;
    logic [RW-1:0] closed_rank;

    // Rank after the target has been taken out of its segment
    always_comb begin
        same_seg_older = tgt_valid && (cur_seg == tgt_seg) && (cur_rank > tgt_rank);
        closed_rank    = same_seg_older ? (cur_rank - RW'(1)) : cur_rank;
    end

    always_comb begin
        nxt_valid = cur_valid;
        nxt_seg   = cur_seg;
        nxt_rank  = cur_rank;
        unique case (ev)
            EV_IDLE, EV_DROP: begin
                nxt_valid = cur_valid;
            end
            EV_HIT: begin
                if (is_tgt) begin
                    nxt_seg  = SEG_PROT;
                    nxt_rank = '0;
                end else if (cur_valid) begin
                    if (tgt_seg == SEG_PROT) begin
                        // reorder inside the protected segment
                        if (cur_seg == SEG_PROT && cur_rank < tgt_rank)
                            nxt_rank = cur_rank + RW'(1);
                    end else begin
                        // promotion out of probation
                        if (cur_seg == SEG_PROB) begin
                            nxt_rank = prot_full ? (closed_rank + RW'(1)) : closed_rank;
                        end else if (prot_full && cur_rank == PROT_LAST) begin
                            nxt_seg  = SEG_PROB;
                            nxt_rank = '0;
                        end else begin
                            nxt_rank = cur_rank + RW'(1);
                        end
                    end
                end
            end
            EV_FILL: begin
                if (is_tgt) begin
                    nxt_valid = 1'b1;
                    nxt_seg   = SEG_PROB;
                    nxt_rank  = '0;
                end else if (cur_valid) begin
                    nxt_rank = (cur_seg == SEG_PROB) ? (closed_rank + RW'(1)) : closed_rank;
                end
            end
            default: begin
                nxt_valid = cur_valid;
            end
        endcase
    end

endmodule

// File: rtl/slru_seg_count.sv
module slru_seg_count #(
    parameter int LINES = 8,
    localparam int CW   = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] valid,
    input  logic [LINES-1:0] seg,
    output logic [CW-1:0]    prob_cnt,
    output logic [CW-1:0]    prot_cnt
);

    always_comb begin
        prob_cnt = '0;
        prot_cnt = '0;
        for (int i = 0; i < LINES; i++) begin
            if (valid[i] && seg[i])  prot_cnt = prot_cnt + CW'(1);
            if (valid[i] && !seg[i]) prob_cnt = prob_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/slru_victim_pick.sv
module slru_victim_pick #(
    parameter int LINES = 8,
    localparam int RW   = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW   = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] valid,
    input  logic [LINES-1:0] seg,
    input  logic [RW-1:0]    rank [LINES],
    input  logic [CW-1:0]    prob_cnt,
    input  logic [CW-1:0]    prot_cnt,
    output logic [RW-1:0]    victim_idx,
    output logic             victim_free
);

    logic [RW-1:0] free_idx, prob_idx, prot_idx;
    logic          any_free;

    always_comb begin
        free_idx = '0;
        prob_idx = '0;
        prot_idx = '0;
        any_free = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = RW'(i);
                any_free = 1'b1;
            end
            if (valid[i] && !seg[i] && int'(rank[i]) == int'(prob_cnt) - 1)
                prob_idx = RW'(i);
            if (valid[i] && seg[i] && int'(rank[i]) == int'(prot_cnt) - 1)
                prot_idx = RW'(i);
        end
    end

    always_comb begin
        victim_free = any_free;
        if (any_free)
            victim_idx = free_idx;
        else if (prob_cnt != '0)
            victim_idx = prob_idx;
        else
            victim_idx = prot_idx;
    end

endmodule

// File: rtl/slru_ctrl.sv
module slru_ctrl
    import slru_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int PROT_CAP = 3,
    localparam int RW      = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW      = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_en,
    input  logic [RW-1:0] hit_idx,
    input  logic          fill_en,
    input  logic [RW-1:0] fill_idx,
    output logic [RW-1:0] victim_idx,
    output logic          victim_free
);

    logic [LINES-1:0] valid_vec, seg_vec;
    logic [RW-1:0]    rank_arr [LINES];
    logic [LINES-1:0] nxt_valid, nxt_seg;
    logic [RW-1:0]    nxt_rank [LINES];
    logic [CW-1:0]    prob_cnt, prot_cnt;

    ev_e           ev;
    logic [RW-1:0] tgt_idx;
    logic          tgt_valid, tgt_seg, prot_full;
    logic [RW-1:0] tgt_rank;

    // Event decode: hit has priority over fill
    always_comb begin
        tgt_idx = hit_idx;
        unique casez ({hit_en, fill_en})
            2'b1?: begin
                ev      = valid_vec[hit_idx] ? EV_HIT : EV_DROP;
                tgt_idx = hit_idx;
            end
            2'b01: begin
                ev      = EV_FILL;
                tgt_idx = fill_idx;
            end
            default: begin
                ev      = EV_IDLE;
                tgt_idx = hit_idx;
            end
        endcase
    end

    always_comb begin
        tgt_valid = valid_vec[tgt_idx];
        tgt_seg   = seg_vec[tgt_idx];
        tgt_rank  = rank_arr[tgt_idx];
        prot_full = int'(prot_cnt) >= PROT_CAP;
    end

    slru_seg_count #(.LINES(LINES)) u_count (
        .valid    (valid_vec),
        .seg      (seg_vec),
        .prob_cnt (prob_cnt),
        .prot_cnt (prot_cnt)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        slru_line_next #(.LINES(LINES), .PROT_CAP(PROT_CAP)) u_next (
            .ev        (ev),
            .is_tgt    (tgt_idx == RW'(g)),
            .cur_valid (valid_vec[g]),
            .cur_seg   (seg_vec[g]),
            .cur_rank  (rank_arr[g]),
            .tgt_valid (tgt_valid),
            .tgt_seg   (tgt_seg),
            .tgt_rank  (tgt_rank),
            .prot_full (prot_full),
            .nxt_valid (nxt_valid[g]),
            .nxt_seg   (nxt_seg[g]),
            .nxt_rank  (nxt_rank[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_vec <= '0;
            seg_vec   <= '0;
            for (int i = 0; i < LINES; i++) rank_arr[i] <= '0;
        end else begin
            valid_vec <= nxt_valid;
            seg_vec   <= nxt_seg;
            for (int i = 0; i < LINES; i++) rank_arr[i] <= nxt_rank[i];
        end
    end

    // Outputs
    slru_victim_pick #(.LINES(LINES)) u_pick (
        .valid       (valid_vec),
        .seg         (seg_vec),
        .rank        (rank_arr),
        .prob_cnt    (prob_cnt),
        .prot_cnt    (prot_cnt),
        .victim_idx  (victim_idx),
        .victim_free (victim_free)
    );

endmodule

// File: rtl/slru_ctrl_chk.sv
module slru_ctrl_chk #(
    parameter int LINES    = 8,
    parameter int PROT_CAP = 3,
    localparam int RW      = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW      = $clog2(LINES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_en,
    input logic [RW-1:0]    hit_idx,
    input logic             fill_en,
    input logic [RW-1:0]    fill_idx,
    input logic [RW-1:0]    victim_idx,
    input logic             victim_free,
    input logic [LINES-1:0] valid_vec,
    input logic [CW-1:0]    prob_cnt,
    input logic [CW-1:0]    prot_cnt
);

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

    a_r4_prot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(prot_cnt) <= PROT_CAP);

    a_r2_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !hit_en) |=> valid_vec[$past(fill_idx)]);

    a_r9_hit_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !valid_vec[hit_idx]) |=> (valid_vec == $past(valid_vec)));

    a_r10_fill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && fill_en && !valid_vec[fill_idx]) |=> !valid_vec[$past(fill_idx)]);

    a_r6_free_victim: assert property (@(posedge clk) disable iff (!rst_n)
        victim_free |-> !valid_vec[victim_idx]);

    a_r7_full_victim: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_free |-> (&valid_vec));

    a_r2_count_total: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(prot_cnt) + int'(prob_cnt)) == $countones(valid_vec));

    a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((valid_vec & $past(valid_vec)) == $past(valid_vec)));

endmodule

bind slru_ctrl slru_ctrl_chk #(.LINES(LINES), .PROT_CAP(PROT_CAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_en      (hit_en),
    .hit_idx     (hit_idx),
    .fill_en     (fill_en),
    .fill_idx    (fill_idx),
    .victim_idx  (victim_idx),
    .victim_free (victim_free),
    .valid_vec   (valid_vec),
    .prob_cnt    (prob_cnt),
    .prot_cnt    (prot_cnt)
);

// File: tb/slru_ctrl_tb.sv
module slru_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int CAP = 3;
    localparam int IW  = $clog2(N);
    localparam int N2  = 4;
    localparam int IW2 = $clog2(N2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_en = 1'b0, fill_en = 1'b0;
    logic [IW-1:0] hit_idx = '0, fill_idx = '0;
    logic [IW-1:0] victim_idx;
    logic victim_free;

    logic b_hit_en = 1'b0, b_fill_en = 1'b0;
    logic [IW2-1:0] b_hit_idx = '0, b_fill_idx = '0;
    logic [IW2-1:0] b_victim_idx;
    logic b_victim_free;

    int n_checks = 0;
    int n_errors = 0;

    // Reference lists: element 0 is most recent
    int prob_q[$];
    int prot_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slru_ctrl #(.LINES(N), .PROT_CAP(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hit_en(hit_en), .hit_idx(hit_idx),
        .fill_en(fill_en), .fill_idx(fill_idx),
        .victim_idx(victim_idx), .victim_free(victim_free)
    );

    slru_ctrl #(.LINES(N2), .PROT_CAP(N2)) u_dut_full (
        .clk(clk), .rst_n(rst_n),
        .hit_en(b_hit_en), .hit_idx(b_hit_idx),
        .fill_en(b_fill_en), .fill_idx(b_fill_idx),
        .victim_idx(b_victim_idx), .victim_free(b_victim_free)
    );

    function automatic int q_find(ref int q[$], input int v);
        for (int k = 0; k < q.size(); k++) if (q[k] == v) return k;
        return -1;
    endfunction

    function automatic void model_apply(input bit h, input int hi, input bit f, input int fi);
        int p;
        if (h) begin
            p = q_find(prot_q, hi);
            if (p >= 0) begin
                prot_q.delete(p);
                prot_q.push_front(hi);
            end else begin
                p = q_find(prob_q, hi);
                if (p >= 0) begin
                    prob_q.delete(p);
                    prot_q.push_front(hi);
                    if (prot_q.size() > CAP) prob_q.push_front(prot_q.pop_back());
                end
            end
        end else if (f) begin
            p = q_find(prot_q, fi);
            if (p >= 0) prot_q.delete(p);
            p = q_find(prob_q, fi);
            if (p >= 0) prob_q.delete(p);
            prob_q.push_front(fi);
        end
    endfunction

    function automatic int model_victim(output bit free);
        free = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (q_find(prob_q, k) < 0 && q_find(prot_q, k) < 0) begin
                free = 1'b1;
                return k;
            end
        end
        if (prob_q.size() > 0) return prob_q[prob_q.size()-1];
        return prot_q[prot_q.size()-1];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_victim(input string tag);
        bit ef;
        int ei;
        ei = model_victim(ef);
        check({tag, " victim_idx"}, int'(victim_idx), ei);
        check({tag, " victim_free"}, int'(victim_free), int'(ef));
    endtask

    task automatic step(input bit h, input int hi, input bit f, input int fi, input string tag);
        @(negedge clk);
        hit_en = h; hit_idx = IW'(hi); fill_en = f; fill_idx = IW'(fi);
        @(posedge clk);
        model_apply(h, hi, f, fi);
        @(negedge clk);
        hit_en = 1'b0; fill_en = 1'b0;
        check_victim(tag);
    endtask

    task automatic bstep(input bit h, input int hi, input bit f, input int fi);
        @(negedge clk);
        b_hit_en = h; b_hit_idx = IW2'(hi); b_fill_en = f; b_fill_idx = IW2'(fi);
        @(negedge clk);
        b_hit_en = 1'b0; b_fill_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        prob_q.delete();
        prot_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        check("R1 victim_idx", int'(victim_idx), 0);
        check("R1 victim_free", int'(victim_free), 1);

        // R2/R6: fills in order, lowest invalid named
        for (int k = 0; k < N; k++) step(1'b0, 0, 1'b1, k, "R2 R6 fill");
        // R7: all valid, oldest probation line (0)
        check("R7 victim_idx", int'(victim_idx), 0);
        check("R7 victim_free", int'(victim_free), 0);

        step(1'b1, 0, 1'b0, 0, "R3 promote");           // victim 1
        check("R3 victim_idx", int'(victim_idx), 1);
        step(1'b1, 1, 1'b0, 0, "R3 promote");
        step(1'b1, 2, 1'b0, 0, "R3 promote");           // victim 3
        step(1'b1, 3, 1'b0, 0, "R4 overflow");          // 0 demoted, victim 4
        check("R4 victim_idx", int'(victim_idx), 4);
        step(1'b1, 3, 1'b0, 0, "R5 at MRU");
        step(1'b1, 1, 1'b0, 0, "R5 reorder");
        check("R5 victim_idx", int'(victim_idx), 4);
        step(1'b0, 0, 1'b1, 4, "R11 refill");           // victim 5
        check("R11 victim_idx", int'(victim_idx), 5);
        step(1'b0, 0, 1'b1, 0, "R11 refill demoted");

        // R9 / R10 from a fresh state
        do_reset();
        for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b1, k, "R6 fill");
        step(1'b1, 5, 1'b0, 0, "R9 hit invalid");
        check("R9 victim_idx", int'(victim_idx), 5);
        step(1'b1, 0, 1'b1, 5, "R10 both strobes");
        check("R10 victim_idx", int'(victim_idx), 5);
        check("R10 victim_free", int'(victim_free), 1);

        // R8: second instance, protected capacity equals line count
        for (int k = 0; k < N2; k++) bstep(1'b0, 0, 1'b1, k);
        for (int k = 0; k < N2; k++) bstep(1'b1, k, 1'b0, 0);
        check("R8 victim_idx", int'(b_victim_idx), 0);
        check("R8 victim_free", int'(b_victim_free), 0);
        bstep(1'b1, 0, 1'b0, 0);
        check("R8 victim_idx after rehit", int'(b_victim_idx), 1);

        // Random mix against the reference lists (R2 R3 R4 R5 R7 R11)
        do_reset();
        for (int s = 0; s < 3000; s++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 4)
                step(1'b0, 0, 1'b1, int'(victim_idx), "R2 R7 random fill");
            else if (r < 5)
                step(1'b0, 0, 1'b1, int'($urandom % N), "R11 random refill");
            else
                step(1'b1, int'($urandom % N), 1'b0, 0, "R3 R4 R5 random hit");
        end
        finish_run();
    end

endmodule